// File: doc/BRIEF.md
# Watermarked Command Ring Reader

This block is the consuming end of a circular command buffer that lives in memory. Software programs the ring limits (a lower bound and an exclusive upper bound), the two pointers, a high and a low fill threshold and a stop address. A producer signals each finished 32-byte burst with a one-cycle pulse. The reader keeps a fill count and fetches one 32-byte line at a time from memory. It hands each line downstream before it moves its read pointer.

Fetching is gated by three things. The first is a read enable. The second is the fill-threshold flags, when their interrupts are enabled. The third is a stop-address match. In linked mode each producer pulse advances the write pointer and the threshold logic is live. In buffer mode the write pointer moves only by software, and reading simply continues while the ring holds data.

The memory request is a valid/ready channel: once raised, the request holds its address until accepted. The response and downstream channels are valid/ready and joined combinationally while a line is in flight. Downstream back-pressure stalls the response. Control, status and interrupt pins are plain levels.

Top module: `cmdring_reader`

## Requirements
- R1: After reset the control register reads 0x10 (linked mode on, all else off), status reads 0x0C, both pointers, the limits, the thresholds and the stop address read 0, and no memory request or interrupt is raised.
- R2: Registers are selected by a 4-bit word index: 0 control, 1 status (read-only), 2 clear (write-only, reads 0), 3 lower bound, 4 upper bound, 5 high threshold, 6 low threshold, 7 fill count (read-only), 8 write pointer, 9 read pointer, 10 stop address. All address-type fields hold byte addresses whose bits 4:0 read as zero whatever is written.
- R3: When the engine is idle, control bit 0 (read enable) is set, the fill count is nonzero and nothing stalls, a request is raised with address equal to the read pointer. The request keeps its valid and address unchanged until accepted.
- R4: Only one line is in flight. Its response is passed downstream, with response-ready equal to downstream-ready. The read pointer advances by 32 when downstream accepts the line, going from the upper bound back to the lower bound, so lines leave in ring order.
- R5: With control bit 4 (linked mode) set, each producer pulse advances the write pointer by 32 with the same wrap. With bit 4 clear the pulse has no effect.
- R6: The fill count is (write pointer − read pointer) modulo (upper − lower bound), reported in bytes.
- R7: In linked mode a count above the high threshold sets sticky status bit 0. Writing the clear register with bit 0 set clears it, unless the condition still holds. The overflow interrupt is status bit 0 AND control bit 2.
- R8: In linked mode a count below the low threshold sets sticky status bit 1. Clear register bit 1 clears it, unless the condition still holds. The underflow interrupt is status bit 1 AND control bit 3.
- R9: While an enabled threshold flag is set or its condition holds, no new request is raised. In buffer mode the threshold flags are not set and reading continues until the count is zero.
- R10: With control bit 1 set, a read pointer equal to the stop address sets sticky status bit 4 and blocks new requests. Control bit 5 routes it to the stop interrupt. Clearing control bit 1 clears the flag.
- R11: Status bit 2 is set while no line is requested or in flight. Status bit 3 is set when that holds and the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| prod_burst | input | 1 | One pulse per producer 32-byte burst |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request accepted |
| rd_req_addr | output | AW | Line byte address |
| rsp_valid | input | 1 | Memory response valid |
| rsp_ready | output | 1 | Memory response ready |
| rsp_data | input | LINE_BITS | Memory response line |
| out_valid | output | 1 | Line valid downstream |
| out_ready | input | 1 | Downstream ready |
| out_data | output | LINE_BITS | Line data downstream |
| irq_ovf | output | 1 | High-fill interrupt |
| irq_udf | output | 1 | Low-fill interrupt |
| irq_brk | output | 1 | Stop-address interrupt |

## Verification
The bench builds the block with AW = 12 and LINE_BITS = 32. This gives a 7-bit line index, so an eight-line ring sits between 0x100 and 0x200. With that ring, wrap of both pointers, a count that spans the wrap and a stall that leaves a single line behind are all reached in a few dozen cycles. The narrow line lets the memory model stamp each line with its own address, so order and content are checked together under periodic back-pressure on both the request and downstream channels.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
  localparam int LINE_SHIFT = 5;

  typedef enum logic [3:0] {
    RA_CTRL = 4'd0,
    RA_STAT = 4'd1,
    RA_CLR  = 4'd2,
    RA_BASE = 4'd3,
    RA_TOP  = 4'd4,
    RA_HI   = 4'd5,
    RA_LO   = 4'd6,
    RA_CNT  = 4'd7,
    RA_WPTR = 4'd8,
    RA_RPTR = 4'd9,
    RA_BRK  = 4'd10
  } reg_idx_e;

  localparam int C_RDEN  = 0;
  localparam int C_BRKEN = 1;
  localparam int C_OVFIE = 2;
  localparam int C_UDFIE = 3;
  localparam int C_LINK  = 4;
  localparam int C_BRKIE = 5;
  localparam logic [5:0] CTRL_RST = 6'b01_0000;

  typedef enum logic [1:0] {ENG_IDLE, ENG_REQ, ENG_WAIT} eng_state_e;
endpackage

// File: rtl/cmdring_regs.sv
module cmdring_regs
  import cmdring_pkg::*;
#(
  parameter int AW = 26,
  parameter int PW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [3:0]    addr,
  input  logic [31:0]   wdata,
  input  logic          prod_burst,
  input  logic          rd_adv,
  output logic [5:0]    ctrl,
  output logic          clr_ovf,
  output logic          clr_udf,
  output logic [PW-1:0] base,
  output logic [PW-1:0] top,
  output logic [PW-1:0] hi,
  output logic [PW-1:0] lo,
  output logic [PW-1:0] brk,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] rptr
);
  logic [PW-1:0] wfield;
  logic          unused_hi;

  assign wfield    = wdata[LINE_SHIFT +: PW];
  assign unused_hi = ^wdata[31:AW];
  assign clr_ovf   = wr && (addr == RA_CLR) && wdata[0];
  assign clr_udf   = wr && (addr == RA_CLR) && wdata[1];

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p,
                                         input logic [PW-1:0] lb,
                                         input logic [PW-1:0] ub);
    logic [PW-1:0] inc;
    inc  = p + 1'b1;
    step = (inc == ub) ? lb : inc;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= CTRL_RST;
      base <= '0;
      top  <= '0;
      hi   <= '0;
      lo   <= '0;
      brk  <= '0;
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr) begin
        case (addr)
          RA_CTRL: ctrl <= wdata[5:0];
          RA_BASE: base <= wfield;
          RA_TOP:  top  <= wfield;
          RA_HI:   hi   <= wfield;
          RA_LO:   lo   <= wfield;
          RA_BRK:  brk  <= wfield;
          default: ;
        endcase
      end
      if (wr && addr == RA_WPTR)
        wptr <= wfield;
      else if (prod_burst && ctrl[C_LINK])
        wptr <= step(wptr, base, top);
      if (wr && addr == RA_RPTR)
        rptr <= wfield;
      else if (rd_adv)
        rptr <= step(rptr, base, top);
    end
  end
endmodule

// File: rtl/cmdring_status.sv
module cmdring_status
  import cmdring_pkg::*;
#(
  parameter int PW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [5:0]    ctrl,
  input  logic [PW-1:0] base,
  input  logic [PW-1:0] top,
  input  logic [PW-1:0] hi,
  input  logic [PW-1:0] lo,
  input  logic [PW-1:0] brk,
  input  logic [PW-1:0] wptr,
  input  logic [PW-1:0] rptr,
  input  logic          clr_ovf,
  input  logic          clr_udf,
  output logic [PW-1:0] count,
  output logic          ovf_flag,
  output logic          udf_flag,
  output logic          brk_flag,
  output logic          stall
);
  logic ovf_cond, udf_cond, brk_cond;

  assign count    = wptr - rptr + ((wptr < rptr) ? (top - base) : '0);
  assign ovf_cond = ctrl[C_LINK] && (count > hi);
  assign udf_cond = ctrl[C_LINK] && (count < lo);
  assign brk_cond = ctrl[C_BRKEN] && (rptr == brk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
      brk_flag <= 1'b0;
    end else begin
      ovf_flag <= (ovf_flag && !clr_ovf) || ovf_cond;
      udf_flag <= (udf_flag && !clr_udf) || udf_cond;
      brk_flag <= brk_cond || (brk_flag && ctrl[C_BRKEN]);
    end
  end

  assign stall = (ctrl[C_OVFIE] && (ovf_flag || ovf_cond))
              || (ctrl[C_UDFIE] && (udf_flag || udf_cond))
              || brk_flag || brk_cond;
endmodule

// File: rtl/cmdring_engine.sv
module cmdring_engine
  import cmdring_pkg::*;
#(
  parameter int AW        = 26,
  parameter int PW        = 21,
  parameter int LINE_BITS = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [PW-1:0]        rptr,
  output logic                 rd_req_valid,
  input  logic                 rd_req_ready,
  output logic [AW-1:0]        rd_req_addr,
  input  logic                 rsp_valid,
  output logic                 rsp_ready,
  input  logic [LINE_BITS-1:0] rsp_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [LINE_BITS-1:0] out_data,
  output logic                 rd_adv,
  output logic                 idle
);
  eng_state_e    state_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      addr_q  <= '0;
    end else begin
      case (state_q)
        ENG_IDLE: if (go) begin
          state_q <= ENG_REQ;
          addr_q  <= {rptr, {LINE_SHIFT{1'b0}}};
        end
        ENG_REQ:  if (rd_req_ready) state_q <= ENG_WAIT;
        ENG_WAIT: if (rsp_valid && out_ready) state_q <= ENG_IDLE;
        default:  state_q <= ENG_IDLE;
      endcase
    end
  end

  assign idle         = (state_q == ENG_IDLE);
  assign rd_req_valid = (state_q == ENG_REQ);
  assign rd_req_addr  = addr_q;
  assign rsp_ready    = (state_q == ENG_WAIT) && out_ready;
  assign out_valid    = (state_q == ENG_WAIT) && rsp_valid;
  assign out_data     = rsp_data;
  assign rd_adv       = (state_q == ENG_WAIT) && rsp_valid && out_ready;
endmodule

// File: rtl/cmdring_reader.sv
module cmdring_reader
  import cmdring_pkg::*;
#(
  parameter int AW        = 26,
  parameter int LINE_BITS = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [3:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 prod_burst,
  output logic                 rd_req_valid,
  input  logic                 rd_req_ready,
  output logic [AW-1:0]        rd_req_addr,
  input  logic                 rsp_valid,
  output logic                 rsp_ready,
  input  logic [LINE_BITS-1:0] rsp_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [LINE_BITS-1:0] out_data,
  output logic                 irq_ovf,
  output logic                 irq_udf,
  output logic                 irq_brk
);
  localparam int PW = AW - LINE_SHIFT;

  logic [5:0]    ctrl;
  logic          clr_ovf, clr_udf, rd_adv, idle, stall, go;
  logic          ovf_flag, udf_flag, brk_flag;
  logic [PW-1:0] base, top, hi, lo, brk, wptr, rptr, count;

  cmdring_regs #(.AW(AW), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .prod_burst(prod_burst), .rd_adv(rd_adv), .ctrl(ctrl),
    .clr_ovf(clr_ovf), .clr_udf(clr_udf), .base(base), .top(top),
    .hi(hi), .lo(lo), .brk(brk), .wptr(wptr), .rptr(rptr)
  );

  cmdring_status #(.PW(PW)) u_status (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .base(base), .top(top),
    .hi(hi), .lo(lo), .brk(brk), .wptr(wptr), .rptr(rptr),
    .clr_ovf(clr_ovf), .clr_udf(clr_udf), .count(count),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag), .brk_flag(brk_flag), .stall(stall)
  );

  assign go = ctrl[C_RDEN] && (count != '0) && !stall;

  cmdring_engine #(.AW(AW), .PW(PW), .LINE_BITS(LINE_BITS)) u_engine (
    .clk(clk), .rst_n(rst_n), .go(go), .rptr(rptr),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .rd_adv(rd_adv), .idle(idle)
  );

  assign irq_ovf = ovf_flag && ctrl[C_OVFIE];
  assign irq_udf = udf_flag && ctrl[C_UDFIE];
  assign irq_brk = brk_flag && ctrl[C_BRKIE];

  function automatic logic [31:0] fld(input logic [PW-1:0] v);
    fld = '0;
    fld[LINE_SHIFT +: PW] = v;
  endfunction

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = {26'd0, ctrl};
      RA_STAT: reg_rdata = {27'd0, brk_flag, idle && (count == '0), idle, udf_flag, ovf_flag};
      RA_BASE: reg_rdata = fld(base);
      RA_TOP:  reg_rdata = fld(top);
      RA_HI:   reg_rdata = fld(hi);
      RA_LO:   reg_rdata = fld(lo);
      RA_CNT:  reg_rdata = fld(count);
      RA_WPTR: reg_rdata = fld(wptr);
      RA_RPTR: reg_rdata = fld(rptr);
      RA_BRK:  reg_rdata = fld(brk);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cmdring_reader_chk.sv
module cmdring_reader_chk #(
  parameter int AW = 26
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic [AW-1:0] rd_req_addr,
  input logic          rsp_ready,
  input logic          out_valid,
  input logic          irq_ovf,
  input logic          irq_udf,
  input logic          irq_brk
);
  // R3: an unaccepted request keeps valid and address
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  // R4: after acceptance no second request until the line is done
  a_r4_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && rd_req_ready |=> !rd_req_valid);

  // R4: response and downstream are never active while a request is pending
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || rsp_ready) |-> !rd_req_valid);

  // R9: no new request starts while a threshold interrupt is up
  a_r9_no_issue_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_valid) |-> !$past(irq_ovf) && !$past(irq_udf));

  // R10: no new request starts while the stop interrupt is up
  a_r10_no_issue_on_brk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_valid) |-> !$past(irq_brk));
endmodule

bind cmdring_reader cmdring_reader_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_req_addr(rd_req_addr), .rsp_ready(rsp_ready), .out_valid(out_valid),
  .irq_ovf(irq_ovf), .irq_udf(irq_udf), .irq_brk(irq_brk)
);

// File: tb/test_cmdring_reader.sv
module test_cmdring_reader;
  localparam int AW = 12;
  localparam int LB = 32;
  localparam logic [11:0] RING_LO = 12'h100;
  localparam logic [11:0] RING_HI = 12'h200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          prod_burst = 1'b0;
  logic          rd_req_valid, rsp_ready, out_valid;
  logic          rd_req_ready = 1'b0;
  logic [AW-1:0] rd_req_addr;
  logic          rsp_valid = 1'b0;
  logic [LB-1:0] rsp_data = '0;
  logic          out_ready = 1'b0;
  logic [LB-1:0] out_data;
  logic          irq_ovf, irq_udf, irq_brk;

  int n_chk = 0;
  int n_bad = 0;
  int n_out = 0;
  logic [11:0] exp_q[$];
  logic [11:0] m_rptr;

  always #10 clk = ~clk;

  cmdring_reader #(.AW(AW), .LINE_BITS(LB)) i_cmdring_reader (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prod_burst(prod_burst),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .irq_ovf(irq_ovf), .irq_udf(irq_udf), .irq_brk(irq_brk)
  );

  function automatic logic [LB-1:0] line_of(input logic [11:0] a);
    return {16'hC0DE, 4'h0, a};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // memory model and scoreboard monitor: drive at negedge, then sample
  int  cyc = 0;
  bit  req_fire = 0, rsp_fire = 0, pend = 0;
  int  dly = 0;
  logic [11:0] req_addr_q = '0, paddr = '0;
  always @(negedge clk) begin
    cyc++;
    out_ready    = (cyc % 5) != 0;
    rd_req_ready = (cyc % 3) != 1;
    if (rsp_fire) rsp_valid = 1'b0;
    if (req_fire) begin pend = 1; paddr = req_addr_q; dly = 1; end
    if (pend && !rsp_valid) begin
      if (dly == 0) begin rsp_valid = 1'b1; rsp_data = line_of(paddr); pend = 0; end
      else dly--;
    end
    #1;
    req_fire   = rd_req_valid && rd_req_ready;
    req_addr_q = rd_req_addr;
    rsp_fire   = rsp_valid && rsp_ready;
    if (out_valid && out_ready) begin
      n_out++;
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R4: unexpected line actual 0x%0h expected none", out_data);
      end else begin
        check("R4 line order/content", out_data, line_of(exp_q.pop_front()));
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #2; d = reg_rdata;
  endtask

  task automatic burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); prod_burst = 1'b1;
      @(negedge clk); prod_burst = 1'b0;
    end
  endtask

  task automatic expect_lines(input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(m_rptr);
      m_rptr = (m_rptr + 12'h20 == RING_HI) ? RING_LO : m_rptr + 12'h20;
    end
  endtask

  task automatic idle_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base_out;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle_cyc(2);
    // R1 reset state
    rd(4'd0, v);  check("R1 control reset", v, 32'h10);
    rd(4'd1, v);  check("R1 status reset", v, 32'h0C);
    rd(4'd8, v);  check("R1 write pointer reset", v, 32'h0);
    check("R1 no request/irq", {rd_req_valid, irq_ovf, irq_udf, irq_brk}, 4'b0);
    // R2 field alignment
    wr(4'd3, 32'h11F);
    rd(4'd3, v);  check("R2 lower bound low bits zero", v, 32'h100);
    rd(4'd2, v);  check("R2 clear reads zero", v, 32'h0);
    wr(4'd4, 32'h200); wr(4'd8, 32'h100); wr(4'd9, 32'h100);
    m_rptr = 12'h100;
    // R5/R6 linked bursts, then R3/R4 reads
    burst(3);
    rd(4'd8, v);  check("R5 write pointer after 3 bursts", v, 32'h160);
    rd(4'd7, v);  check("R6 count 3 lines", v, 32'h60);
    expect_lines(3);
    wr(4'd0, 32'h11);
    idle_cyc(30);
    check("R4 three lines delivered", exp_q.size(), 0);
    rd(4'd1, v);  check("R11 idle and empty", v & 32'hC, 32'hC);
    // R5/R6 wrap
    wr(4'd0, 32'h10);
    burst(5);
    rd(4'd8, v);  check("R5 write pointer wraps", v, 32'h100);
    rd(4'd7, v);  check("R6 count across wrap", v, 32'hA0);
    expect_lines(5);
    wr(4'd0, 32'h11);
    idle_cyc(50);
    check("R4 wrapped lines delivered", exp_q.size(), 0);
    rd(4'd9, v);  check("R4 read pointer wraps", v, 32'h100);
    // R7/R9 overflow
    wr(4'd5, 32'h60); wr(4'd2, 32'h1);
    wr(4'd0, 32'h14);
    burst(4);
    idle_cyc(2);
    rd(4'd1, v);  check("R7 overflow status", v & 32'h1, 32'h1);
    check("R7 overflow irq", irq_ovf, 1'b1);
    base_out = n_out;
    wr(4'd0, 32'h15);
    idle_cyc(20);
    check("R9 no reads while overflow irq", n_out - base_out, 0);
    rd(4'd1, v);  check("R11 idle with data", v & 32'hC, 32'h4);
    wr(4'd5, 32'h7E0);
    expect_lines(4);
    wr(4'd2, 32'h1);
    idle_cyc(40);
    check("R7 reads after clear", exp_q.size(), 0);
    check("R7 irq cleared", irq_ovf, 1'b0);
    // R8/R9 underflow
    wr(4'd0, 32'h18); wr(4'd6, 32'h40);
    idle_cyc(2);
    check("R8 underflow irq", irq_udf, 1'b1);
    burst(3);
    base_out = n_out;
    wr(4'd0, 32'h19);
    idle_cyc(20);
    check("R9 no reads while underflow irq", n_out - base_out, 0);
    expect_lines(2);
    wr(4'd2, 32'h2);
    idle_cyc(40);
    check("R9 stops at one line left", exp_q.size(), 0);
    rd(4'd7, v);  check("R8 count left", v, 32'h20);
    check("R8 irq back", irq_udf, 1'b1);
    // R5/R9 buffer mode
    wr(4'd0, 32'h08); wr(4'd2, 32'h3);
    idle_cyc(2);
    rd(4'd1, v);  check("R9 flags clear in buffer mode", v & 32'h3, 32'h0);
    burst(1);
    rd(4'd8, v);  check("R5 burst ignored in buffer mode", v, 32'h1E0);
    wr(4'd8, 32'h120);
    expect_lines(3);
    wr(4'd0, 32'h09);
    idle_cyc(50);
    check("R9 buffer mode drains", exp_q.size(), 0);
    rd(4'd9, v);  check("R9 read pointer after drain", v, 32'h120);
    check("R9 no underflow in buffer mode", irq_udf, 1'b0);
    // R10 stop address
    wr(4'd0, 32'h10); wr(4'd10, 32'h160);
    burst(4);
    expect_lines(2);
    wr(4'd0, 32'h33);
    idle_cyc(40);
    check("R10 lines before stop", exp_q.size(), 0);
    rd(4'd9, v);  check("R10 read pointer held", v, 32'h160);
    rd(4'd1, v);  check("R10 stop status", v & 32'h10, 32'h10);
    check("R10 stop irq", irq_brk, 1'b1);
    expect_lines(2);
    wr(4'd0, 32'h11);
    idle_cyc(40);
    check("R10 resume after disable", exp_q.size(), 0);
    rd(4'd1, v);  check("R10 status cleared", v & 32'h10, 32'h0);
    check("R10 irq cleared", irq_brk, 1'b0);
    rd(4'd9, v);  check("R10 final read pointer", v, 32'h1A0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule